// File: doc/BRIEF.md
# Character LCD Nibble Bus Transactor

This block carries single-byte transfers between a host and a character display controller that uses a 4-bit parallel data bus with register-select (RS), read/write (RW) and enable (E) strobes. The host asks for one of three operations: write a byte, read a byte, or wait until the display reports ready. The block cuts every byte into two nibble transfers and times each E pulse from clock-cycle counts derived from the clock frequency. It orders the bus signals so that the setup, pulse-width, hold and cycle-time limits hold.

For reads, the block turns off its data drivers, raises RW and samples the returned nibble in the last clock cycle that E is high. The wait-ready operation reads the status byte again and again until its busy flag is clear, and returns the last status byte it read. The pad drivers are modelled as a 4-bit output value, one output-enable and a 4-bit input. The host side uses a request/ready handshake, and the block answers each accepted request with a one-cycle done pulse.

Top module: `lcd_nibble_xfer`

## Requirements
- R1: Each write or read moves its byte as two E pulses on the 4-bit bus: bits 7..4 on the first pulse and bits 3..0 on the second.
- R2: Each E pulse stays high for exactly ceil(E_HIGH_NS x CLK_MHZ / 1000) clock cycles, which is 100 cycles at the default parameters.
- R3: RS, RW, the output nibble and the output-enable are stable for at least the setup count of cycles before E rises. They do not change while E is high, and they are held for at least the hold count of cycles after E falls.
- R4: On a write, RW is 0, the data output-enable is 1 and RS equals the requested RS bit on both pulses.
- R5: On a read, RW is 1 and the data output-enable is 0 on both pulses. In the cycle that done is high, RW is back at 0 and the output-enable is back at 1.
- R6: The byte returned by a read is made from the two nibbles present on the data input during the last high cycle of each E pulse, with the first pulse giving bits 7..4.
- R7: Wait-ready forces RS to 0 whatever the requested RS is. It reads whole status bytes until one has bit 7 equal to 0, and it returns that byte.
- R8: Successive rising edges of E are at least ceil(CYCLE_NS x CLK_MHZ / 1000) cycles apart, which is 200 cycles at the defaults.
- R9: reqReady is high only while no operation is in progress. A request is taken when reqValid and reqReady are both high, and reqValid has no effect while an operation is in progress.
- R10: The reqOp encoding is 00 for write, 01 for read, and 10 or 11 for wait-ready. rspDone is a one-cycle pulse. rspRdata is updated only by reads and wait-ready, and a write leaves it unchanged.
- R11: After reset, reqReady is 1, E is 0, RW is 0, the output-enable is 1, rspDone is 0 and rspRdata is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| reqValid | input | 1 | Host request valid |
| reqReady | output | 1 | Block idle and able to take a request |
| reqOp | input | 2 | Operation code |
| reqRs | input | 1 | Register select for write and read |
| reqWdata | input | 8 | Byte to write |
| rspDone | output | 1 | One-cycle completion pulse |
| rspRdata | output | 8 | Byte from the last read or wait-ready |
| lcdRs | output | 1 | Register select to the display |
| lcdRw | output | 1 | Read (1) or write (0) to the display |
| lcdE | output | 1 | Enable strobe |
| lcdDataOut | output | 4 | Nibble driven onto the bus |
| lcdDataOe | output | 1 | Data driver enable |
| lcdDataIn | input | 4 | Nibble read from the bus |

## Verification
The display model in the bench drives the inverted nibble on the data input in every cycle except the final high cycle of E. A design that samples one cycle early, or after E has fallen, therefore returns the complement of the expected byte. The model checks the width of every E pulse, the spacing between rising edges, and the setup and hold windows around each pulse. A design that starts the second nibble too soon, or switches RW before the hold window ends, is reported on that pulse. Wait-ready runs against a status that stays busy for several bytes, to catch a block that stops after the first poll or decides on a half-read byte. A request held during a transfer must produce neither extra pulses nor a second done.

// File: rtl/lcdnb_pkg.sv
package lcdnb_pkg;

  localparam logic [1:0] OP_WRITE = 2'b00;
  localparam logic [1:0] OP_READ  = 2'b01;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_SETUP,
    ST_EHIGH,
    ST_HOLD,
    ST_DONE
  } lcdnbState_t;

  typedef struct packed {
    logic load;       // capture the host request
    logic busActive;  // present the transfer's RS/RW/nibble/drive
    logic eHigh;      // enable strobe level
    logic sample;     // capture the input nibble
    logic lowNib;     // which half of the byte is on the bus
    logic finish;     // release the bus and signal done
  } lcdnbStrobes_t;

  function automatic int nsToCycles(input int ns, input int clkMhz);
    int c;
    c = (ns * clkMhz + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

endpackage

// File: rtl/lcdnb_ctrl.sv
module lcdnb_ctrl
  import lcdnb_pkg::*;
#(
  parameter int SETUP_CYC = 8,
  parameter int EHIGH_CYC = 100,
  parameter int HOLD_CYC  = 4,
  parameter int CYCLE_CYC = 200
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          reqValid,
  input  logic [1:0]    reqOp,
  input  logic          busyFlag,
  output logic          reqReady,
  output lcdnbStrobes_t strobes
);

  localparam int PH_MAX_A = (SETUP_CYC > EHIGH_CYC) ? SETUP_CYC : EHIGH_CYC;
  localparam int PH_MAX   = (PH_MAX_A > HOLD_CYC) ? PH_MAX_A : HOLD_CYC;
  localparam int PH_W     = $clog2(PH_MAX + 1);
  localparam int GAP_W    = $clog2(CYCLE_CYC + 1);
  localparam logic [PH_W-1:0]  PH_SAT     = PH_W'(PH_MAX);
  localparam logic [PH_W-1:0]  SETUP_LAST = PH_W'(SETUP_CYC - 1);
  localparam logic [PH_W-1:0]  EHIGH_LAST = PH_W'(EHIGH_CYC - 1);
  localparam logic [PH_W-1:0]  HOLD_LAST  = PH_W'(HOLD_CYC - 1);
  localparam logic [GAP_W-1:0] GAP_SAT    = GAP_W'(CYCLE_CYC - 1);

  lcdnbState_t      state, stateNext;
  logic [PH_W-1:0]  phaseCnt;
  logic [GAP_W-1:0] gapCnt;
  logic             nibLow, nibLowNext;
  logic             isWait;
  logic             riseNow;

  always_comb begin
    stateNext  = state;
    nibLowNext = nibLow;
    unique case (state)
      ST_IDLE: begin
        if (reqValid) begin
          stateNext  = ST_SETUP;
          nibLowNext = 1'b0;
        end
      end
      ST_SETUP: begin
        if (phaseCnt >= SETUP_LAST && gapCnt >= GAP_SAT) stateNext = ST_EHIGH;
      end
      ST_EHIGH: begin
        if (phaseCnt == EHIGH_LAST) stateNext = ST_HOLD;
      end
      ST_HOLD: begin
        if (phaseCnt == HOLD_LAST) begin
          if (!nibLow) begin
            stateNext  = ST_SETUP;
            nibLowNext = 1'b1;
          end else if (isWait && busyFlag) begin
            stateNext  = ST_SETUP;
            nibLowNext = 1'b0;
          end else begin
            stateNext  = ST_DONE;
            nibLowNext = 1'b0;
          end
        end
      end
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  assign riseNow = (state == ST_SETUP) && (stateNext == ST_EHIGH);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state    <= ST_IDLE;
      phaseCnt <= '0;
      gapCnt   <= GAP_SAT;
      nibLow   <= 1'b0;
      isWait   <= 1'b0;
    end else begin
      state  <= stateNext;
      nibLow <= nibLowNext;
      if (stateNext != state) phaseCnt <= '0;
      else if (phaseCnt != PH_SAT) phaseCnt <= phaseCnt + 1'b1;
      if (riseNow) gapCnt <= '0;
      else if (gapCnt != GAP_SAT) gapCnt <= gapCnt + 1'b1;
      if (state == ST_IDLE && reqValid) isWait <= reqOp[1];
    end
  end

  assign reqReady = (state == ST_IDLE);

  always_comb begin
    strobes.load      = (state == ST_IDLE) && reqValid;
    strobes.busActive = (state == ST_SETUP) || (state == ST_EHIGH) || (state == ST_HOLD);
    strobes.eHigh     = (state == ST_EHIGH);
    strobes.sample    = (state == ST_HOLD) && (phaseCnt == '0);
    strobes.lowNib    = nibLow;
    strobes.finish    = (state == ST_DONE);
  end

  AST_ACCEPT_CLOSES: assert property (@(posedge clk) disable iff (!rstN)
    reqValid && reqReady |=> !reqReady); // R9

  AST_DONE_FROM_BUSY: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |-> !reqReady); // R9

endmodule

// File: rtl/lcdnb_datapath.sv
module lcdnb_datapath
  import lcdnb_pkg::*;
#(
  parameter int EHIGH_CYC = 100,
  parameter int CYCLE_CYC = 200
) (
  input  logic          clk,
  input  logic          rstN,
  input  lcdnbStrobes_t strobes,
  input  logic [1:0]    reqOp,
  input  logic          reqRs,
  input  logic [7:0]    reqWdata,
  input  logic [3:0]    lcdDataIn,
  output logic          busyFlag,
  output logic          rspDone,
  output logic [7:0]    rspRdata,
  output logic          lcdRs,
  output logic          lcdRw,
  output logic          lcdE,
  output logic [3:0]    lcdDataOut,
  output logic          lcdDataOe
);

  localparam int CHK_W = $clog2(CYCLE_CYC + EHIGH_CYC + 2);
  localparam logic [CHK_W-1:0] CHK_SAT = {CHK_W{1'b1}};

  logic       opRead;
  logic       rsEff;
  logic [7:0] wByte;
  logic [7:0] rdByte;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      opRead     <= 1'b0;
      rsEff      <= 1'b0;
      wByte      <= '0;
      rdByte     <= '0;
      rspDone    <= 1'b0;
      rspRdata   <= '0;
      lcdRs      <= 1'b0;
      lcdRw      <= 1'b0;
      lcdE       <= 1'b0;
      lcdDataOut <= '0;
      lcdDataOe  <= 1'b1;
    end else begin
      if (strobes.load) begin
        opRead <= (reqOp != OP_WRITE);
        rsEff  <= reqOp[1] ? 1'b0 : reqRs;
        wByte  <= reqWdata;
      end
      if (strobes.busActive) begin
        lcdRw      <= opRead;
        lcdDataOe  <= !opRead;
        lcdRs      <= rsEff;
        lcdDataOut <= strobes.lowNib ? wByte[3:0] : wByte[7:4];
      end else begin
        lcdRw     <= 1'b0;
        lcdDataOe <= 1'b1;
      end
      lcdE <= strobes.eHigh;
      if (strobes.sample) begin
        if (strobes.lowNib) rdByte[3:0] <= lcdDataIn;
        else                rdByte[7:4] <= lcdDataIn;
      end
      rspDone <= strobes.finish;
      if (strobes.finish && opRead) rspRdata <= rdByte;
    end
  end

  assign busyFlag = rdByte[7];

  // pin-level timing monitors for the assertions below
  logic             ePrev;
  logic [CHK_W-1:0] eRun;
  logic [CHK_W-1:0] pinGap;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ePrev  <= 1'b0;
      eRun   <= '0;
      pinGap <= CHK_SAT;
    end else begin
      ePrev <= lcdE;
      if (lcdE) begin
        if (eRun != CHK_SAT) eRun <= eRun + 1'b1;
      end else begin
        eRun <= '0;
      end
      if (lcdE && !ePrev) pinGap <= CHK_W'(1);
      else if (pinGap != CHK_SAT) pinGap <= pinGap + 1'b1;
    end
  end

  AST_E_WIDTH: assert property (@(posedge clk) disable iff (!rstN)
    (!lcdE && ePrev) |-> (eRun == CHK_W'(EHIGH_CYC))); // R2

  AST_BUS_STILL_IN_E: assert property (@(posedge clk) disable iff (!rstN)
    (lcdE && ePrev) |-> $stable({lcdRs, lcdRw, lcdDataOut, lcdDataOe})); // R3

  AST_RISE_SPACING: assert property (@(posedge clk) disable iff (!rstN)
    (lcdE && !ePrev) |-> (pinGap >= CHK_W'(CYCLE_CYC))); // R8

  AST_NO_DRIVE_ON_READ: assert property (@(posedge clk) disable iff (!rstN)
    lcdRw |-> !lcdDataOe); // R5

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |=> !rspDone); // R10

  AST_DONE_BUS_FREE: assert property (@(posedge clk) disable iff (!rstN)
    rspDone |-> (!lcdRw && lcdDataOe && !lcdE)); // R5

endmodule

// File: rtl/lcd_nibble_xfer.sv
module lcd_nibble_xfer
  import lcdnb_pkg::*;
#(
  parameter int CLK_MHZ   = 200,
  parameter int E_HIGH_NS = 500,
  parameter int SETUP_NS  = 40,
  parameter int HOLD_NS   = 20,
  parameter int CYCLE_NS  = 1000
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       reqValid,
  output logic       reqReady,
  input  logic [1:0] reqOp,
  input  logic       reqRs,
  input  logic [7:0] reqWdata,
  output logic       rspDone,
  output logic [7:0] rspRdata,
  output logic       lcdRs,
  output logic       lcdRw,
  output logic       lcdE,
  output logic [3:0] lcdDataOut,
  output logic       lcdDataOe,
  input  logic [3:0] lcdDataIn
);

  localparam int SETUP_CYC = nsToCycles(SETUP_NS, CLK_MHZ);
  localparam int EHIGH_CYC = nsToCycles(E_HIGH_NS, CLK_MHZ);
  localparam int HOLD_CYC  = nsToCycles(HOLD_NS, CLK_MHZ);
  localparam int CYCLE_RAW = nsToCycles(CYCLE_NS, CLK_MHZ);
  localparam int CYCLE_MIN = SETUP_CYC + EHIGH_CYC + HOLD_CYC;
  localparam int CYCLE_CYC = (CYCLE_RAW > CYCLE_MIN) ? CYCLE_RAW : CYCLE_MIN;

  lcdnbStrobes_t strobes;
  logic          busyFlag;

  lcdnb_ctrl #(
    .SETUP_CYC(SETUP_CYC),
    .EHIGH_CYC(EHIGH_CYC),
    .HOLD_CYC (HOLD_CYC),
    .CYCLE_CYC(CYCLE_CYC)
  ) u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .reqValid(reqValid),
    .reqOp   (reqOp),
    .busyFlag(busyFlag),
    .reqReady(reqReady),
    .strobes (strobes)
  );

  lcdnb_datapath #(
    .EHIGH_CYC(EHIGH_CYC),
    .CYCLE_CYC(CYCLE_CYC)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .reqOp     (reqOp),
    .reqRs     (reqRs),
    .reqWdata  (reqWdata),
    .lcdDataIn (lcdDataIn),
    .busyFlag  (busyFlag),
    .rspDone   (rspDone),
    .rspRdata  (rspRdata),
    .lcdRs     (lcdRs),
    .lcdRw     (lcdRw),
    .lcdE      (lcdE),
    .lcdDataOut(lcdDataOut),
    .lcdDataOe (lcdDataOe)
  );

endmodule

// File: tb/lcd_nibble_xfer_tb.sv
module lcd_nibble_xfer_tb;

  localparam int CLK_MHZ   = 200;
  localparam int SETUP_CYC = (40 * CLK_MHZ + 999) / 1000;
  localparam int EH_CYC    = (500 * CLK_MHZ + 999) / 1000;
  localparam int HOLD_CYC  = (20 * CLK_MHZ + 999) / 1000;
  localparam int CYCLE_CYC = (1000 * CLK_MHZ + 999) / 1000;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic       reqReady;
  logic [1:0] reqOp = 2'b00;
  logic       reqRs = 1'b0;
  logic [7:0] reqWdata = 8'h00;
  logic       rspDone;
  logic [7:0] rspRdata;
  logic       lcdRs, lcdRw, lcdE, lcdDataOe;
  logic [3:0] lcdDataOut;
  logic [3:0] lcdDataIn = 4'h0;

  always #2.5 clk = ~clk;

  lcd_nibble_xfer u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqOp(reqOp), .reqRs(reqRs), .reqWdata(reqWdata),
    .rspDone(rspDone), .rspRdata(rspRdata),
    .lcdRs(lcdRs), .lcdRw(lcdRw), .lcdE(lcdE),
    .lcdDataOut(lcdDataOut), .lcdDataOe(lcdDataOe), .lcdDataIn(lcdDataIn)
  );

  int  checks = 0;
  int  errors = 0;
  bit  finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // display model
  logic [6:0] busNow;
  assign busNow = {lcdRs, lcdRw, lcdDataOut, lcdDataOe};

  logic [6:0] busPrev = '0, snap = '0;
  logic       ePrevTb = 1'b0;
  int         eCnt = 0, stableCnt = 0, holdCnt = 0;
  bit         holdPend = 0, haveRise = 0;
  int         cyc = 0, lastRise = 0;
  int         logCnt = 0, doneCnt = 0;
  logic [3:0] logNib [64];
  logic       logRs [64];
  logic       logRw [64];
  logic       logOe [64];
  logic [7:0] rdVal = 8'h00;
  int         pollsLeft = 0;
  bit         rdNibIdx = 0;

  always @(posedge clk) cyc++;

  always @(negedge clk) begin
    logic [7:0] curByte;
    logic [3:0] nib;
    if (rstN) begin
      if (lcdE && !ePrevTb) begin
        chk(stableCnt >= SETUP_CYC, "R3 setup before E rise", stableCnt, SETUP_CYC);
        if (haveRise) chk(cyc - lastRise >= CYCLE_CYC, "R8 E rise spacing", cyc - lastRise, CYCLE_CYC);
        haveRise = 1; lastRise = cyc; eCnt = 1; holdPend = 0;
      end else if (lcdE) begin
        chk(busNow == busPrev, "R3 bus stable while E high", int'(busNow), int'(busPrev));
        eCnt++;
      end else if (ePrevTb) begin
        chk(eCnt == EH_CYC, "R2 E high width", eCnt, EH_CYC);
        if (logCnt < 64) begin
          logNib[logCnt] = lcdDataOut; logRs[logCnt] = lcdRs;
          logRw[logCnt] = lcdRw; logOe[logCnt] = lcdDataOe;
        end
        logCnt++;
        holdPend = 1; holdCnt = 1; snap = busNow;
        if (lcdRw) begin
          if (rdNibIdx && pollsLeft > 0) pollsLeft--;
          rdNibIdx = !rdNibIdx;
        end
      end else if (holdPend) begin
        if (busNow != snap) begin
          chk(holdCnt >= HOLD_CYC, "R3 hold after E fall", holdCnt, HOLD_CYC);
          holdPend = 0;
        end else holdCnt++;
      end
      stableCnt = (busNow == busPrev) ? stableCnt + 1 : 1;
      busPrev = busNow;
      ePrevTb = lcdE;
      if (rspDone) doneCnt++;
      curByte = (pollsLeft > 0) ? {1'b1, 7'h15} : rdVal;
      nib = rdNibIdx ? curByte[3:0] : curByte[7:4];
      lcdDataIn = (lcdE && eCnt == EH_CYC) ? nib : ~nib;
    end
  end

  task automatic doOp(input logic [1:0] op, input logic rs, input logic [7:0] wd);
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logCnt = 0; rdNibIdx = 0;
    reqValid = 1'b1; reqOp = op; reqRs = rs; reqWdata = wd;
    @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone) @(negedge clk);
  endtask

  initial begin
    repeat (4) @(negedge clk);
    chk(reqReady == 1'b1, "R11 reqReady at reset", reqReady, 1);
    chk(lcdE == 1'b0 && lcdRw == 1'b0, "R11 E and RW at reset", {lcdE, lcdRw}, 0);
    chk(lcdDataOe == 1'b1, "R11 output-enable at reset", lcdDataOe, 1);
    chk(rspDone == 1'b0 && rspRdata == 8'h00, "R11 response at reset", {rspDone, rspRdata}, 0);
    rstN = 1'b1;

    // write sweep
    for (int i = 0; i < 16; i++) begin
      logic [7:0] b;
      logic       rs;
      b  = 8'(i * 29) ^ 8'hA5;
      rs = i[0];
      doOp(2'b00, rs, b);
      chk(logCnt == 2, "R1 two pulses per write", logCnt, 2);
      chk(logNib[0] == b[7:4], "R1 high nibble first", logNib[0], b[7:4]);
      chk(logNib[1] == b[3:0], "R1 low nibble second", logNib[1], b[3:0]);
      chk(logRs[0] == rs && logRs[1] == rs, "R4 RS on write", {logRs[0], logRs[1]}, {rs, rs});
      chk(!logRw[0] && !logRw[1] && logOe[0] && logOe[1], "R4 RW low and driving",
          {logRw[0], logRw[1], logOe[0], logOe[1]}, 4'b0011);
      chk(rspRdata == 8'h00, "R10 write leaves rspRdata", rspRdata, 0);
    end

    // read sweep
    for (int i = 0; i < 16; i++) begin
      logic       rs;
      rdVal = 8'(i * 55) + 8'h0C;
      rs = i[1];
      doOp(2'b01, rs, 8'(i));
      chk(rspRdata == rdVal, "R6 read byte from last high cycle", rspRdata, rdVal);
      chk(logCnt == 2, "R1 two pulses per read", logCnt, 2);
      chk(logRw[0] && logRw[1] && !logOe[0] && !logOe[1], "R5 RW high, drivers off",
          {logRw[0], logRw[1], logOe[0], logOe[1]}, 4'b1100);
      chk(logRs[0] == rs && logRs[1] == rs, "R5 RS on read", {logRs[0], logRs[1]}, {rs, rs});
      chk(!lcdRw && lcdDataOe, "R5 bus released at done", {lcdRw, lcdDataOe}, 2'b01);
    end

    // write after read keeps last read value
    rdVal = 8'h00;
    doOp(2'b00, 1'b1, 8'h3C);
    chk(rspRdata == 8'(15 * 55) + 8'h0C, "R10 write keeps rspRdata", rspRdata, 8'(15 * 55) + 8'h0C);

    // wait-ready with several busy polls
    pollsLeft = 3; rdVal = 8'h2B;
    doOp(2'b10, 1'b1, 8'h00);
    chk(rspRdata == 8'h2B, "R7 wait returns ready status", rspRdata, 8'h2B);
    chk(logCnt == 8, "R7 polls until busy clear", logCnt, 8);
    begin
      bit allLow = 1;
      for (int k = 0; k < 8; k++) if (logRs[k] || !logRw[k]) allLow = 0;
      chk(allLow, "R7 RS low status reads", allLow, 1);
    end

    // wait-ready already ready, alternate encoding
    pollsLeft = 0; rdVal = 8'h7F;
    doOp(2'b11, 1'b1, 8'h00);
    chk(rspRdata == 8'h7F, "R10 op 11 acts as wait-ready", rspRdata, 8'h7F);
    chk(logCnt == 2, "R7 single poll when ready", logCnt, 2);

    // request held during a write is ignored
    @(negedge clk);
    while (!reqReady) @(negedge clk);
    logCnt = 0; doneCnt = 0;
    reqValid = 1'b1; reqOp = 2'b00; reqRs = 1'b0; reqWdata = 8'h96;
    @(negedge clk);
    reqOp = 2'b01;
    repeat (50) @(negedge clk);
    chk(reqReady == 1'b0, "R9 not ready while busy", reqReady, 0);
    repeat (50) @(negedge clk);
    reqValid = 1'b0;
    while (!rspDone) @(negedge clk);
    repeat (400) @(negedge clk);
    chk(logCnt == 2, "R9 held request caused no transfer", logCnt, 2);
    chk(doneCnt == 1, "R9 single done", doneCnt, 1);
    chk(logNib[0] == 4'h9 && logNib[1] == 4'h6 && !logRw[0], "R9 first request written",
        {logNib[0], logNib[1]}, 8'h96);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog actual=expired expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule